// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block governs the test-mode-select line of one downstream local scan port that hangs off a main test access port. At any time the local port is either unparked, in which case its test-mode-select copies the main one and the local TAP controller steps in lockstep with the main TAP controller, or parked, in which case the line is held at a constant so the local TAP sits still in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. An unparked indication from this block is what the surrounding chain routing uses to splice the local port into the active scan path. A parked port is taken out of that path.

Four decoded instruction pulses drive it: park-in-reset, park-in-idle, park-in-pause and unpark. Parking in reset or idle happens at once. Parking in pause is armed by its instruction and takes place as the main controller leaves Exit1-DR or Exit1-IR towards Update. Unparking is deferred until the main controller reaches a state that matches where the local port waits, so both controllers resume from the same state. All state, including the local test-mode-select, is registered on the falling edge of TCK. The main test-mode-select is assumed to be settled before that falling edge, and the local TAP samples a stable value on the following rising edge. All pins are plain control and status signals. Nothing in the block carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `lsp_park_ctrl`

## Requirements
- R1: While the port is unparked, each falling edge of `tck` copies `tms_main` to `tms_local`. The local TAP then takes the same state as the main TAP at every rising edge, and `port_active` is 1.
- R2: A park-in-reset pulse seen at a falling edge while unparked sets `park_loc` to 1. From that edge on, `tms_local` is held at 1 for as long as the port stays there, and the local TAP reaches Test-Logic-Reset within five rising edges.
- R3: A park-in-idle pulse seen at a falling edge while unparked sets `park_loc` to 2 and drives `tms_local` to 0 from that edge. When issued in Update-IR, this leaves the local TAP in Run-Test/Idle.
- R4: A park-in-pause pulse arms pause parking on an unparked port. At a later falling edge where `main_state` is Exit1-DR (5) or Exit1-IR (12) and `tms_main` is 1, `park_loc` becomes 3 or 4 respectively and `tms_local` goes to 0, so the local TAP rests in Pause-DR or Pause-IR.
- R5: A port parked at code 1 or 2 with an unpark pending unparks at the first falling edge where `main_state` is Run-Test/Idle (1) and `tms_main` is 0. It never unparks at any other edge.
- R6: A port parked at code 3 or 4 with an unpark pending unparks at the first falling edge where `main_state` is the matching Pause-DR (6) or Pause-IR (13). It never unparks at any other edge.
- R7: `port_active` is 1 exactly when `park_loc` is 0 (unparked). Every parked location gives `port_active` 0.
- R8: Park pulses are ignored by a parked port: `park_loc` and `tms_local` keep their values. Any park pulse cancels a pending unpark.
- R9: When several pulses coincide, only one is taken, in this order: park-in-reset, park-in-idle, park-in-pause, unpark.
- R10: While `trst_n` is low, the port is parked at code 1 with `tms_local` at 1 and `port_active` at 0, and there is no pending unpark and no armed pause park.
- R11: An unpark pulse on an unparked port has no effect. A pending unpark is consumed when the port unparks, so a later visit to the matching state does not change anything.

Main TAP state codes on `main_state`: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its falling edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms_main | input | 1 | Main test-mode-select |
| main_state | input | 4 | Current main TAP controller state code |
| cmd_unpark | input | 1 | Decoded unpark instruction pulse |
| cmd_park_tlr | input | 1 | Decoded park-in-reset instruction pulse |
| cmd_park_rti | input | 1 | Decoded park-in-idle instruction pulse |
| cmd_park_pause | input | 1 | Decoded park-in-pause instruction pulse |
| tms_local | output | 1 | Test-mode-select to the local scan port |
| port_active | output | 1 | High while the port is unparked and in the scan chain |
| park_loc | output | 3 | 0 unparked, 1 reset, 2 idle, 3 Pause-DR, 4 Pause-IR |

## Verification
Inputs are applied one nanosecond after a rising edge of `tck`. Every registered result (`tms_local`, `port_active`, `park_loc`) is due at the very next falling edge, half a cycle later, so the bench compares all three 2 ns after that falling edge against its model, which advances once per cycle. Effects on the local TAP controller appear one rising edge later still, so the lockstep and parked-state checks on the bench's local TAP model are judged against the location recorded in the previous cycle. The one exception is reset parking, which is allowed five rising edges.

// File: rtl/lsp_park_pkg.sv
package lsp_park_pkg;

  localparam int TAP_W = 4;
  localparam int LOC_W = 3;
  localparam int CMD_N = 4;

  typedef enum logic [TAP_W-1:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PA_DR  = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PA_IR  = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_st_e;

  typedef enum logic [LOC_W-1:0] {
    LOC_UNPARKED = 3'd0,
    LOC_TLR      = 3'd1,
    LOC_RTI      = 3'd2,
    LOC_PDR      = 3'd3,
    LOC_PIR      = 3'd4
  } park_loc_e;

  // Packed in priority order, most significant first.
  typedef struct packed {
    logic park_tlr;
    logic park_rti;
    logic park_pause;
    logic unpark;
  } lsp_cmd_t;

endpackage

// File: rtl/lsp_cmd_prio.sv
module lsp_cmd_prio
  import lsp_park_pkg::*;
(
  input  logic [CMD_N-1:0] raw_i,
  output lsp_cmd_t         cmd_o,
  output logic             any_park_o
);

  logic [CMD_N-1:0] grant;

  // Fixed priority: highest index wins.
  always_comb begin
    grant = '0;
    for (int i = CMD_N - 1; i >= 0; i--) begin
      if (raw_i[i] && (grant == '0)) begin
        grant[i] = 1'b1;
      end
    end
  end

  assign cmd_o      = lsp_cmd_t'(grant);
  assign any_park_o = |raw_i[CMD_N-1:1];

endmodule

// File: rtl/lsp_loc_next.sv
module lsp_loc_next
  import lsp_park_pkg::*;
(
  input  park_loc_e loc_q,
  input  tap_st_e   st_i,
  input  logic      tms_i,
  input  lsp_cmd_t  cmd_i,
  input  logic      pending_q,
  input  logic      arm_q,
  output park_loc_e loc_d,
  output logic      unpark_now_o,
  output logic      pause_park_now_o
);

  logic idle_ready;
  logic pdr_ready;
  logic pir_ready;

  assign idle_ready = pending_q && (st_i == ST_RTI) && !tms_i;
  assign pdr_ready  = pending_q && (st_i == ST_PA_DR);
  assign pir_ready  = pending_q && (st_i == ST_PA_IR);

  always_comb begin
    loc_d = loc_q;
    unique case (loc_q)
      LOC_UNPARKED: begin
        if (cmd_i.park_tlr) begin
          loc_d = LOC_TLR;
        end else if (cmd_i.park_rti) begin
          loc_d = LOC_RTI;
        end else if (arm_q && tms_i && (st_i == ST_EX1_DR)) begin
          loc_d = LOC_PDR;
        end else if (arm_q && tms_i && (st_i == ST_EX1_IR)) begin
          loc_d = LOC_PIR;
        end
      end
      LOC_TLR, LOC_RTI: begin
        if (idle_ready) loc_d = LOC_UNPARKED;
      end
      LOC_PDR: begin
        if (pdr_ready) loc_d = LOC_UNPARKED;
      end
      LOC_PIR: begin
        if (pir_ready) loc_d = LOC_UNPARKED;
      end
      default: loc_d = LOC_TLR;
    endcase
  end

  assign unpark_now_o     = (loc_q != LOC_UNPARKED) && (loc_d == LOC_UNPARKED);
  assign pause_park_now_o = (loc_q == LOC_UNPARKED) &&
                            ((loc_d == LOC_PDR) || (loc_d == LOC_PIR));

endmodule

// File: rtl/lsp_flags.sv
module lsp_flags
  import lsp_park_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  park_loc_e loc_q,
  input  lsp_cmd_t  cmd_i,
  input  logic      any_park_i,
  input  logic      unpark_now_i,
  input  logic      pause_park_now_i,
  output logic      pending_q,
  output logic      arm_q
);

  logic pending_d;
  logic arm_d;
  logic parked;

  assign parked = (loc_q != LOC_UNPARKED);

  always_comb begin
    pending_d = pending_q;
    if (any_park_i) begin
      pending_d = 1'b0;
    end else if (cmd_i.unpark && parked) begin
      pending_d = 1'b1;
    end else if (unpark_now_i) begin
      pending_d = 1'b0;
    end
  end

  always_comb begin
    arm_d = arm_q;
    if (cmd_i.park_pause && !parked) begin
      arm_d = 1'b1;
    end else if (cmd_i.park_tlr || cmd_i.park_rti || cmd_i.unpark) begin
      arm_d = 1'b0;
    end else if (pause_park_now_i) begin
      arm_d = 1'b0;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pending_q <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      arm_q     <= arm_d;
    end
  end

  // R11
  pending_only_when_parked_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (loc_q == LOC_UNPARKED) |-> !pending_q);

endmodule

// File: rtl/lsp_out_reg.sv
module lsp_out_reg
  import lsp_park_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  park_loc_e loc_d,
  input  logic      tms_i,
  input  tap_st_e   st_i,
  output park_loc_e loc_q,
  output logic      tms_local_q
);

  logic tms_local_d;

  always_comb begin
    unique case (loc_d)
      LOC_UNPARKED: tms_local_d = tms_i;
      LOC_TLR:      tms_local_d = 1'b1;
      default:      tms_local_d = 1'b0;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      loc_q       <= LOC_TLR;
      tms_local_q <= 1'b1;
    end else begin
      loc_q       <= loc_d;
      tms_local_q <= tms_local_d;
    end
  end

  // R1
  follow_main_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (loc_q == LOC_UNPARKED) |-> (tms_local_q == $past(tms_i)));

  // R2
  tlr_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (loc_q == LOC_TLR) |-> tms_local_q);

  // R3
  low_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
    ((loc_q == LOC_RTI) || (loc_q == LOC_PDR) || (loc_q == LOC_PIR)) |-> !tms_local_q);

  // R4
  pause_entry_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (($past(loc_q) == LOC_UNPARKED) && (loc_q == LOC_PDR)) |->
      (($past(st_i) == ST_EX1_DR) && $past(tms_i)));

  // R5
  idle_unpark_chk: assert property (@(negedge tck) disable iff (!trst_n)
    ((($past(loc_q) == LOC_TLR) || ($past(loc_q) == LOC_RTI)) && (loc_q == LOC_UNPARKED)) |->
      (($past(st_i) == ST_RTI) && !$past(tms_i)));

  // R6
  pause_unpark_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (($past(loc_q) == LOC_PIR) && (loc_q == LOC_UNPARKED)) |-> ($past(st_i) == ST_PA_IR));

endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl
  import lsp_park_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms_main,
  input  logic [TAP_W-1:0] main_state,
  input  logic             cmd_unpark,
  input  logic             cmd_park_tlr,
  input  logic             cmd_park_rti,
  input  logic             cmd_park_pause,
  output logic             tms_local,
  output logic             port_active,
  output logic [LOC_W-1:0] park_loc
);

  tap_st_e   st;
  lsp_cmd_t  cmd;
  logic      any_park;
  park_loc_e loc_q;
  park_loc_e loc_d;
  logic      pending_q;
  logic      arm_q;
  logic      unpark_now;
  logic      pause_park_now;

  assign st = tap_st_e'(main_state);

  lsp_cmd_prio u_prio (
    .raw_i      ({cmd_park_tlr, cmd_park_rti, cmd_park_pause, cmd_unpark}),
    .cmd_o      (cmd),
    .any_park_o (any_park)
  );

  lsp_loc_next u_next (
    .loc_q            (loc_q),
    .st_i             (st),
    .tms_i            (tms_main),
    .cmd_i            (cmd),
    .pending_q        (pending_q),
    .arm_q            (arm_q),
    .loc_d            (loc_d),
    .unpark_now_o     (unpark_now),
    .pause_park_now_o (pause_park_now)
  );

  lsp_flags u_flags (
    .tck              (tck),
    .trst_n           (trst_n),
    .loc_q            (loc_q),
    .cmd_i            (cmd),
    .any_park_i       (any_park),
    .unpark_now_i     (unpark_now),
    .pause_park_now_i (pause_park_now),
    .pending_q        (pending_q),
    .arm_q            (arm_q)
  );

  lsp_out_reg u_out (
    .tck         (tck),
    .trst_n      (trst_n),
    .loc_d       (loc_d),
    .tms_i       (tms_main),
    .st_i        (st),
    .loc_q       (loc_q),
    .tms_local_q (tms_local)
  );

  assign port_active = (loc_q == LOC_UNPARKED);
  assign park_loc    = loc_q;

  // R8
  parked_ignores_park_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (($past(park_loc) != 3'd0) && $past(cmd_park_tlr || cmd_park_rti || cmd_park_pause)) |->
      (park_loc == $past(park_loc)));

endmodule

// File: tb/test_lsp_park_ctrl.sv
module test_lsp_park_ctrl;
  import lsp_park_pkg::*;

  logic       tck = 1'b0;
  logic       trst_n;
  logic       tms_main;
  logic [3:0] main_state;
  logic       cmd_unpark, cmd_park_tlr, cmd_park_rti, cmd_park_pause;
  logic       tms_local, port_active;
  logic [2:0] park_loc;

  always #5 tck = ~tck;

  lsp_park_ctrl i_lsp_park_ctrl (
    .tck(tck), .trst_n(trst_n), .tms_main(tms_main), .main_state(main_state),
    .cmd_unpark(cmd_unpark), .cmd_park_tlr(cmd_park_tlr), .cmd_park_rti(cmd_park_rti),
    .cmd_park_pause(cmd_park_pause), .tms_local(tms_local), .port_active(port_active),
    .park_loc(park_loc)
  );

  int n_cmp = 0;
  int n_bad = 0;

  tap_st_e   main_st, loc_st;
  park_loc_e exp_loc, prev_loc;
  logic      exp_tms, exp_pend, exp_arm;
  string     tag;
  int        tlr_cnt;

  function automatic tap_st_e tap_next(tap_st_e s, logic t);
    case (s)
      ST_TLR:    return t ? ST_TLR    : ST_RTI;
      ST_RTI:    return t ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return t ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return t ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return t ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return t ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  return t ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: return t ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return t ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return t ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return t ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return t ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return t ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  return t ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: return t ? ST_UPD_IR : ST_SH_IR;
      default:   return t ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ops = {park_tlr, park_rti, park_pause, unpark}
  task automatic model_step(input logic t, input tap_st_e st, input logic [3:0] ops);
    logic tlr, rti, pau, unp, any_park, un_now, pz_now;
    park_loc_e nxt;
    tlr = ops[3];
    rti = ops[2] & ~ops[3];
    pau = ops[1] & ~ops[3] & ~ops[2];
    unp = ops[0] & ~(|ops[3:1]);
    any_park = |ops[3:1];
    nxt = exp_loc;
    tag = (exp_loc == LOC_UNPARKED) ? "R1" : "R7";
    case (exp_loc)
      LOC_UNPARKED: begin
        if (tlr) begin nxt = LOC_TLR; tag = "R2"; end
        else if (rti) begin nxt = LOC_RTI; tag = "R3"; end
        else if (exp_arm && t && st == ST_EX1_DR) begin nxt = LOC_PDR; tag = "R4"; end
        else if (exp_arm && t && st == ST_EX1_IR) begin nxt = LOC_PIR; tag = "R4"; end
        else if (unp) tag = "R11";
      end
      LOC_TLR, LOC_RTI: if (exp_pend && st == ST_RTI && !t) begin nxt = LOC_UNPARKED; tag = "R5"; end
      LOC_PDR: if (exp_pend && st == ST_PA_DR) begin nxt = LOC_UNPARKED; tag = "R6"; end
      default: if (exp_pend && st == ST_PA_IR) begin nxt = LOC_UNPARKED; tag = "R6"; end
    endcase
    if (exp_loc != LOC_UNPARKED && any_park) tag = "R8";
    if ($countones(ops) > 1) tag = "R9";
    un_now = (exp_loc != LOC_UNPARKED) && (nxt == LOC_UNPARKED);
    pz_now = (exp_loc == LOC_UNPARKED) && (nxt == LOC_PDR || nxt == LOC_PIR);
    if (any_park) exp_pend = 1'b0;
    else if (unp && exp_loc != LOC_UNPARKED) exp_pend = 1'b1;
    else if (un_now) exp_pend = 1'b0;
    if (pau && exp_loc == LOC_UNPARKED) exp_arm = 1'b1;
    else if (tlr || rti || unp) exp_arm = 1'b0;
    else if (pz_now) exp_arm = 1'b0;
    exp_tms = (nxt == LOC_UNPARKED) ? t : (nxt == LOC_TLR);
    exp_loc = nxt;
  endtask

  task automatic check_outputs();
    chk(tag, int'(tms_local), int'(exp_tms), "tms_local");
    chk(tag, int'(park_loc), int'(exp_loc), "park_loc");
    chk("R7", int'(port_active), int'(exp_loc == LOC_UNPARKED), "port_active");
    if (prev_loc == LOC_UNPARKED) chk("R1", int'(loc_st), int'(main_st), "local tap lockstep");
    if (prev_loc == LOC_RTI) chk("R3", int'(loc_st), int'(ST_RTI), "local tap in idle");
    if (prev_loc == LOC_PDR) chk("R4", int'(loc_st), int'(ST_PA_DR), "local tap in pause-dr");
    if (prev_loc == LOC_PIR) chk("R4", int'(loc_st), int'(ST_PA_IR), "local tap in pause-ir");
    if (tlr_cnt >= 5) chk("R2", int'(loc_st), int'(ST_TLR), "local tap in reset");
  endtask

  task automatic cycle(input logic t, input logic [3:0] ops, input bit rnd);
    logic [3:0] o;
    @(posedge tck); #1;
    main_st = tap_next(main_st, tms_main);
    loc_st  = tap_next(loc_st, tms_local);
    o = ops;
    if (rnd) begin
      o = 4'b0000;
      if (main_st == ST_UPD_IR) begin
        case ($urandom % 7)
          0: o = 4'b0001;
          1: o = 4'b1000;
          2: o = 4'b0100;
          3, 4: o = 4'b0010;
          5: o = 4'(($urandom % 15) + 1);
          default: o = 4'b0001;
        endcase
      end
    end
    main_state = main_st;
    tms_main   = t;
    {cmd_park_tlr, cmd_park_rti, cmd_park_pause, cmd_unpark} = o;
    prev_loc = exp_loc;
    model_step(t, main_st, o);
    tlr_cnt = (prev_loc == LOC_TLR) ? tlr_cnt + 1 : 0;
    @(negedge tck); #2;
    check_outputs();
  endtask

  task automatic do_reset();
    @(posedge tck); #1;
    trst_n = 1'b0;
    tms_main = 1'b1;
    {cmd_park_tlr, cmd_park_rti, cmd_park_pause, cmd_unpark} = 4'b0000;
    main_st = ST_TLR; loc_st = ST_TLR; main_state = ST_TLR;
    exp_loc = LOC_TLR; prev_loc = LOC_TLR; exp_tms = 1'b1; exp_pend = 1'b0; exp_arm = 1'b0;
    tlr_cnt = 0;
    repeat (3) begin
      @(negedge tck); #2;
      chk("R10", int'(tms_local), 1, "tms_local in reset");
      chk("R10", int'(park_loc), 1, "park_loc in reset");
      chk("R10", int'(port_active), 0, "port_active in reset");
    end
    @(posedge tck); #1;
    trst_n = 1'b1;
  endtask

  // Walks the main TAP to Update-IR and applies ops there; ends in Update-IR.
  task automatic load_op(input logic [3:0] op);
    repeat (5) cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, op, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    trst_n = 1'b0;
    tms_main = 1'b1;
    main_state = 4'd0;
    {cmd_park_tlr, cmd_park_rti, cmd_park_pause, cmd_unpark} = 4'b0000;
    do_reset();

    // R5: unpark from reset-park when idle is reached with TMS low
    load_op(4'b0001);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    // R11: unpark again while unparked
    load_op(4'b0001);
    cycle(1'b0, 4'b0, 1'b0);
    // R4: arm pause and park in Pause-DR
    load_op(4'b0010);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    // R8: park pulse on parked port is ignored
    load_op(4'b0100);
    // R6: unpark at Pause-DR
    load_op(4'b0001);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b1, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);
    // R3: park in idle, R9: coincident pulses
    load_op(4'b0101);
    cycle(1'b0, 4'b0, 1'b0);
    cycle(1'b0, 4'b0, 1'b0);

    for (int i = 0; i < 6000; i++) begin
      if (i == 3000) do_reset();
      cycle(($urandom % 100) < 45, 4'b0, 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule